// File: doc/BRIEF.md
# Interrupt Throttle and Cause Controller

This block gathers event strobes from a network controller into a sticky cause register and drives one interrupt line to the host. A mask register selects which causes may raise the line. A throttle interval, counted in units of 256 ns, sets the minimum spacing between two assertions of the line. The spacing is measured from the last assertion that actually took place, not from the event that asks for a new one.

An event that arrives too soon after the last assertion arms a single deferred post, timed for the last assertion plus the interval. Later events leave that time unchanged. Urgent events bypass the throttle. A post that succeeds folds in the cause bits of any receive or transmit delay timers still pending in a companion block, and it sends that block one-cycle cancel strobes. Reading the cause register clears it and drops the line.

Time is a free-running counter of 256 ns ticks. A clock prescaler parameter produces one tick every `TICK_DIV` clocks. The last post time is compared with this counter by wrap-safe subtraction. `rst_n` is expected to be released synchronously to `clk`.

Top module: `irq_throttle_ctrl`

## Requirements
- R1: An event strobe on `evt_i[k]` sets `cause_o[k]` one cycle later, whether or not the line is raised, and the bit stays set until a read-clear.
- R2: The tick counter advances by one every `TICK_DIV` clocks, starting from reset. A deferred post fires at the first clock edge at which the tick count reaches its target, and the line rises one cycle after that edge.
- R3: With a throttle interval of zero, an unmasked event raises `irq_o` one cycle after the strobe.
- R4: An event with `urgent_i` high raises `irq_o` one cycle later, whatever the interval and the time since the last post.
- R5: An event raises the line at once if at least `itv_i` ticks have passed since the last post. Otherwise it only sets its cause bit.
- R6: An event that is not yet due arms a deferred post at last-post tick plus `itv_i`. Further events while it is armed do not move it, and any post cancels it.
- R7: A post does not raise the line when no cause bit is set under the mask. A mask bit of 1 enables the cause at the same position, and the mask resets to all zeros.
- R8: A successful post also sets cause bit 1 (receive timer) if `rx_tmr_pend_i` is high, and cause bit 0 (transmit descriptor written) if `tx_tmr_pend_i` is high. For each timer folded in this way, the matching cancel output pulses for one cycle, together with the rise of the line.
- R9: A successful post sets the asserted status bit, which is the top bit `cause_o[N_CAUSE]`, and records the current tick as the last post time.
- R10: A mask write that leaves no unmasked cause set drops `irq_o`, clears the status bit and cancels an armed deferred post. Unmasking again later does not re-raise the line by itself.
- R11: `rd_clr_i` clears `cause_o` and `irq_o` at the next edge. An event strobe in the same cycle survives the clear.
- R12: After reset, `irq_o`, `cause_o` and both cancel outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_i | input | N_CAUSE | One-cycle cause event strobes |
| urgent_i | input | 1 | Events this cycle bypass the throttle |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | N_CAUSE | New mask value, 1 enables a cause |
| itv_i | input | ITV_W | Throttle interval in 256 ns ticks |
| rd_clr_i | input | 1 | Cause register read strobe, clears on read |
| rx_tmr_pend_i | input | 1 | Receive delay timer pending in companion block |
| tx_tmr_pend_i | input | 1 | Transmit delay timer pending in companion block |
| rx_tmr_cancel_o | output | 1 | One-cycle cancel to the receive delay timer |
| tx_tmr_cancel_o | output | 1 | One-cycle cancel to the transmit delay timer |
| irq_o | output | 1 | Interrupt line to the host |
| cause_o | output | N_CAUSE+1 | Cause register, top bit is the asserted status |

## Verification
The assertions take for granted that the throttle interval stays below half the range of the tick counter. The wrap-safe comparison of the last post time and of the deferred target holds only then. They also assume `itv_i` is held steady while a deferred post is armed, and that the pending-timer inputs are levels sampled at the posting edge. The stimulus keeps every interval at five ticks or less against a 17-bit counter. It changes the interval only while nothing is armed, and it holds each pending-timer input across the whole window in which the deferred post it belongs to can fire.

// File: rtl/irq_thr_pkg.sv
package irq_thr_pkg;
  // cause bit positions decoded by the posting logic
  localparam int CAUSE_TXDW = 0;  // transmit descriptor written
  localparam int CAUSE_RXT  = 1;  // receive timer expired

  // why the throttle asks for a post in a given cycle
  typedef enum logic [1:0] {
    POST_NONE  = 2'd0,
    POST_NOW   = 2'd1,
    POST_DEFER = 2'd2
  } post_src_e;
endpackage

// File: rtl/irq_tick_base.sv
module irq_tick_base #(
  parameter int TICK_DIV = 13,
  parameter int TIME_W   = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TIME_W-1:0] now_o,
  output logic              tick_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(TICK_DIV - 1);

  logic [PW-1:0]     presc_q, presc_d;
  logic [TIME_W-1:0] now_q, now_d;
  logic              tick;

  always_comb begin
    tick    = (presc_q == PLAST);
    presc_d = tick ? '0 : presc_q + 1'b1;
    now_d   = now_q;
    if (tick) now_d = now_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      now_q   <= '0;
    end else begin
      presc_q <= presc_d;
      if (tick) now_q <= now_d;
    end
  end

  assign now_o  = now_q;
  assign tick_o = tick;

  assert_tick_adv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (now_q == TIME_W'($past(now_q) + 1'b1)));
  assert_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(now_q));
endmodule

// File: rtl/irq_throttle.sv
module irq_throttle
  import irq_thr_pkg::*;
#(
  parameter int TIME_W = 17,
  parameter int ITV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_i,
  input  logic [ITV_W-1:0]  itv_i,
  input  logic              evt_any_i,
  input  logic              urgent_i,
  input  logic              post_ok_i,
  input  logic              mask_kill_i,
  output logic              post_req_o
);
  logic [TIME_W-1:0] last_q, last_d;
  logic [TIME_W-1:0] dl_q, dl_d;
  logic              armed_q, armed_d;
  logic              aged_q, aged_d;
  logic [TIME_W-1:0] elapsed, to_target;
  logic              due, defer_due;
  post_src_e         src;

  always_comb begin
    elapsed   = now_i - last_q;
    to_target = now_i - dl_q;
    due       = (itv_i == '0) || aged_q || (elapsed >= TIME_W'(itv_i));
    defer_due = armed_q && !to_target[TIME_W-1];
    if (evt_any_i && (urgent_i || due)) src = POST_NOW;
    else if (defer_due)                 src = POST_DEFER;
    else                                src = POST_NONE;
    post_req_o = (src != POST_NONE);
  end

  always_comb begin
    armed_d = armed_q;
    dl_d    = dl_q;
    if (post_req_o || mask_kill_i) begin
      armed_d = 1'b0;
    end else if (evt_any_i && !armed_q) begin
      armed_d = 1'b1;
      dl_d    = last_q + TIME_W'(itv_i);
    end
    last_d = post_ok_i ? now_i : last_q;
    aged_d = aged_q;
    if (post_ok_i)               aged_d = 1'b0;
    else if (elapsed[TIME_W-1])  aged_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= '0;
      dl_q    <= '0;
      armed_q <= 1'b0;
      aged_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      aged_q  <= aged_d;
      if (post_ok_i) last_q <= last_d;
      if (!armed_q)  dl_q   <= dl_d;
    end
  end

  assert_defer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !post_req_o && !mask_kill_i) |=> (armed_q && $stable(dl_q)));
  assert_post_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    post_req_o |=> !armed_q);
  assert_kill_disarms_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_kill_i |=> !armed_q);
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
  import irq_thr_pkg::*;
#(
  parameter int N_CAUSE = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CAUSE-1:0] evt_i,
  input  logic               rd_clr_i,
  input  logic               mask_we_i,
  input  logic [N_CAUSE-1:0] mask_wdata_i,
  input  logic               post_req_i,
  input  logic               rx_pend_i,
  input  logic               tx_pend_i,
  output logic [N_CAUSE:0]   cause_o,
  output logic               irq_o,
  output logic               rx_cancel_o,
  output logic               tx_cancel_o,
  output logic               post_ok_o,
  output logic               mask_kill_o
);
  logic [N_CAUSE:0]   cause_q, cause_d;
  logic [N_CAUSE-1:0] mask_q, mask_eff, base, raised, folded;
  logic               irq_q, irq_d;
  logic               rxc_q, rxc_d, txc_q, txc_d;
  logic               stat_base, live;

  always_comb begin
    base      = rd_clr_i ? '0 : cause_q[N_CAUSE-1:0];
    stat_base = rd_clr_i ? 1'b0 : cause_q[N_CAUSE];
    raised    = base | evt_i;
    mask_eff  = mask_we_i ? mask_wdata_i : mask_q;
    live      = |(raised & mask_eff);
    post_ok_o   = post_req_i && live;
    mask_kill_o = mask_we_i && !live;
    rxc_d = post_ok_o && rx_pend_i;
    txc_d = post_ok_o && tx_pend_i;
    folded = raised;
    if (rxc_d) folded[CAUSE_RXT]  = 1'b1;
    if (txc_d) folded[CAUSE_TXDW] = 1'b1;
    cause_d[N_CAUSE-1:0] = folded;
    if (post_ok_o)        cause_d[N_CAUSE] = 1'b1;
    else if (mask_kill_o) cause_d[N_CAUSE] = 1'b0;
    else                  cause_d[N_CAUSE] = stat_base;
    if (post_ok_o)                    irq_d = 1'b1;
    else if (mask_kill_o || rd_clr_i) irq_d = 1'b0;
    else                              irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
      rxc_q   <= 1'b0;
      txc_q   <= 1'b0;
    end else begin
      cause_q <= cause_d;
      irq_q   <= irq_d;
      rxc_q   <= rxc_d;
      txc_q   <= txc_d;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign cause_o     = cause_q;
  assign irq_o       = irq_q;
  assign rx_cancel_o = rxc_q;
  assign tx_cancel_o = txc_q;

  assert_evt_sticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q[N_CAUSE-1:0] & $past(evt_i)) == $past(evt_i)));
  assert_rdclr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && (evt_i == '0) && !post_req_i) |=> ((cause_q == '0) && !irq_q));
  assert_post_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (post_req_i && !mask_we_i && (|(evt_i & mask_q))) |=> (irq_q && cause_q[N_CAUSE]));
  assert_mask_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we_i && (mask_wdata_i == '0)) |=> (!irq_q && !cause_q[N_CAUSE]));
  assert_rx_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rxc_q |-> (irq_q && cause_q[CAUSE_RXT]));
  assert_tx_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    txc_q |-> (irq_q && cause_q[CAUSE_TXDW]));
  assert_rise_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> cause_q[N_CAUSE]);
endmodule

// File: rtl/irq_throttle_ctrl.sv
module irq_throttle_ctrl #(
  parameter int N_CAUSE  = 7,
  parameter int TICK_DIV = 13,
  parameter int TIME_W   = 17,
  parameter int ITV_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CAUSE-1:0] evt_i,
  input  logic               urgent_i,
  input  logic               mask_we_i,
  input  logic [N_CAUSE-1:0] mask_wdata_i,
  input  logic [ITV_W-1:0]   itv_i,
  input  logic               rd_clr_i,
  input  logic               rx_tmr_pend_i,
  input  logic               tx_tmr_pend_i,
  output logic               rx_tmr_cancel_o,
  output logic               tx_tmr_cancel_o,
  output logic               irq_o,
  output logic [N_CAUSE:0]   cause_o
);
  logic [TIME_W-1:0] now;
  logic              tick;
  logic              post_req, post_ok, mask_kill;

  irq_tick_base #(.TICK_DIV(TICK_DIV), .TIME_W(TIME_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .now_o(now), .tick_o(tick)
  );

  irq_throttle #(.TIME_W(TIME_W), .ITV_W(ITV_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .now_i(now), .itv_i(itv_i),
    .evt_any_i(|evt_i), .urgent_i(urgent_i), .post_ok_i(post_ok),
    .mask_kill_i(mask_kill), .post_req_o(post_req)
  );

  irq_cause_reg #(.N_CAUSE(N_CAUSE)) u_cause (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_clr_i(rd_clr_i),
    .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
    .post_req_i(post_req), .rx_pend_i(rx_tmr_pend_i), .tx_pend_i(tx_tmr_pend_i),
    .cause_o(cause_o), .irq_o(irq_o), .rx_cancel_o(rx_tmr_cancel_o),
    .tx_cancel_o(tx_tmr_cancel_o), .post_ok_o(post_ok), .mask_kill_o(mask_kill)
  );

  assert_urgent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent_i && !mask_we_i && (|(evt_i & ~cause_o[N_CAUSE-1:0])) && post_ok) |=> irq_o);
  assert_no_rise_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!post_req && !irq_o) |=> !irq_o);
  // the throttle never relies on the tick being idle longer than one clock
  assert_tick_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (TICK_DIV > 1 && tick) |=> !tick);
endmodule

// File: tb/irq_throttle_ctrl_tb.sv
`timescale 1ns/1ps
module irq_throttle_ctrl_tb;
  localparam int DIV = 4;

  typedef struct {
    int         e;
    logic       irq;
    logic [7:0] cause;
    logic       rxc;
    logic       txc;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  evt, mdata;
  logic        urg, mwe, rdclr, rxp, txp;
  logic [15:0] itv;
  logic        rxc, txc, irq;
  logic [7:0]  cause;

  int   ecount;
  int   nchk = 0;
  int   nfail = 0;
  int   lastp = 0;
  int   tgt;
  bit   done = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  irq_throttle_ctrl #(.N_CAUSE(7), .TICK_DIV(DIV), .TIME_W(17), .ITV_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .urgent_i(urg), .mask_we_i(mwe),
    .mask_wdata_i(mdata), .itv_i(itv), .rd_clr_i(rdclr), .rx_tmr_pend_i(rxp),
    .tx_tmr_pend_i(txp), .rx_tmr_cancel_o(rxc), .tx_tmr_cancel_o(txc),
    .irq_o(irq), .cause_o(cause)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  function automatic int nowof(int e);
    return e / DIV;
  endfunction

  task automatic expect_at(int e, logic i, logic [7:0] c, logic rc, logic tc, string tag);
    exp_t x;
    x.e = e; x.irq = i; x.cause = c; x.rxc = rc; x.txc = tc; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic drive(logic [6:0] ev, logic u, logic we, logic [6:0] md, logic rc);
    evt = ev; urg = u; mwe = we; mdata = md; rdclr = rc;
    @(negedge clk);
    evt = '0; urg = 0; mwe = 0; mdata = '0; rdclr = 0;
  endtask

  task automatic idle_until(int e);
    while (ecount < e) @(negedge clk);
  endtask

  // monitor: compares the front of the scoreboard when its cycle comes up
  always begin
    @(negedge clk);
    #2;
    while (q.size() > 0 && q[0].e <= ecount) begin
      nchk++;
      if (q[0].e < ecount) begin
        nfail++;
        $display("FAIL %s: check for cycle %0d missed (now %0d)", q[0].tag, q[0].e, ecount);
      end else if (irq !== q[0].irq || cause !== q[0].cause ||
                   rxc !== q[0].rxc || txc !== q[0].txc) begin
        nfail++;
        $display("FAIL %s @%0d: irq=%b cause=%h rxc=%b txc=%b expected irq=%b cause=%h rxc=%b txc=%b",
                 q[0].tag, ecount, irq, cause, rxc, txc,
                 q[0].irq, q[0].cause, q[0].rxc, q[0].txc);
      end
      void'(q.pop_front());
    end
  end

  initial begin
    #(64'd200000 * 20);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; evt = '0; urg = 0; mwe = 0; mdata = '0; rdclr = 0;
    rxp = 0; txp = 0; itv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_at(ecount + 1, 0, 8'h00, 0, 0, "R12 reset state");
    @(negedge clk);

    // R7/R1: mask resets to zero, so the post is refused but the cause sticks
    expect_at(ecount + 1, 0, 8'h04, 0, 0, "R7 masked post, R1 cause set");
    drive(7'h04, 0, 0, 7'h00, 0);
    expect_at(ecount + 1, 0, 8'h00, 0, 0, "R11 read clears");
    drive(7'h00, 0, 0, 7'h00, 1);
    expect_at(ecount + 1, 0, 8'h00, 0, 0, "R10 enable all, nothing pending");
    drive(7'h00, 0, 1, 7'h7F, 0);

    // R3: zero interval posts at once
    expect_at(ecount + 1, 1, 8'h88, 0, 0, "R3 immediate post, R9 status");
    lastp = nowof(ecount);
    drive(7'h08, 0, 0, 7'h00, 0);
    // R11: event in the read cycle survives, old bit gone
    expect_at(ecount + 1, 1, 8'h90, 0, 0, "R11 event survives clear");
    lastp = nowof(ecount);
    drive(7'h10, 0, 0, 7'h00, 1);
    expect_at(ecount + 1, 0, 8'h00, 0, 0, "R11 clear drops line");
    drive(7'h00, 0, 0, 7'h00, 1);

    // R5/R6/R2: deferred post timed from last post
    itv = 16'd5;
    tgt = lastp + 5;
    expect_at(ecount + 1, 0, 8'h04, 0, 0, "R5 not due yet");
    drive(7'h04, 0, 0, 7'h00, 0);
    @(negedge clk); @(negedge clk);
    expect_at(ecount + 1, 0, 8'h24, 0, 0, "R6 second event no post");
    drive(7'h20, 0, 0, 7'h00, 0);
    expect_at(DIV * tgt, 0, 8'h24, 0, 0, "R2 line low before target tick");
    expect_at(DIV * tgt + 1, 1, 8'hA4, 0, 0, "R6 deferred fires at target");
    idle_until(DIV * tgt + 1);
    lastp = tgt;

    // R4: urgent bypasses throttle
    expect_at(ecount + 1, 0, 8'h00, 0, 0, "R11 clear");
    drive(7'h00, 0, 0, 7'h00, 1);
    expect_at(ecount + 1, 1, 8'h82, 0, 0, "R4 urgent post");
    lastp = nowof(ecount);
    drive(7'h02, 1, 0, 7'h00, 0);

    // R8: deferred post folds pending receive timer
    expect_at(ecount + 1, 0, 8'h00, 0, 0, "R11 clear");
    drive(7'h00, 0, 0, 7'h00, 1);
    tgt = lastp + 5;
    expect_at(ecount + 1, 0, 8'h40, 0, 0, "R5 not due yet");
    drive(7'h40, 0, 0, 7'h00, 0);
    rxp = 1;
    expect_at(DIV * tgt + 1, 1, 8'hC2, 1, 0, "R8 rx timer folded and cancelled");
    expect_at(DIV * tgt + 2, 1, 8'hC2, 0, 0, "R8 rx cancel is one cycle");
    idle_until(DIV * tgt + 1);
    rxp = 0;
    lastp = tgt;
    idle_until(DIV * tgt + 2);

    // R5: due event posts at once
    expect_at(ecount + 1, 0, 8'h00, 0, 0, "R11 clear");
    drive(7'h00, 0, 0, 7'h00, 1);
    idle_until(DIV * (lastp + 5));
    expect_at(ecount + 1, 1, 8'hC0, 0, 0, "R5 interval elapsed posts at once");
    lastp = nowof(ecount);
    drive(7'h40, 0, 0, 7'h00, 0);

    // R8: urgent post folds pending transmit timer
    expect_at(ecount + 1, 0, 8'h00, 0, 0, "R11 clear");
    drive(7'h00, 0, 0, 7'h00, 1);
    txp = 1;
    expect_at(ecount + 1, 1, 8'h89, 0, 1, "R8 tx timer folded and cancelled");
    lastp = nowof(ecount);
    drive(7'h08, 1, 0, 7'h00, 0);
    txp = 0;
    expect_at(ecount + 1, 1, 8'h89, 0, 0, "R8 tx cancel is one cycle");
    @(negedge clk);

    // R10: emptying mask drops line and kills the armed deferred post
    expect_at(ecount + 1, 0, 8'h00, 0, 0, "R11 clear");
    drive(7'h00, 0, 0, 7'h00, 1);
    expect_at(ecount + 1, 1, 8'h90, 0, 0, "R4 urgent post");
    lastp = nowof(ecount);
    drive(7'h10, 1, 0, 7'h00, 0);
    tgt = lastp + 5;
    expect_at(ecount + 1, 1, 8'hB0, 0, 0, "R6 arm while line high");
    drive(7'h20, 0, 0, 7'h00, 0);
    expect_at(ecount + 1, 0, 8'h30, 0, 0, "R10 mask empties, line and status drop");
    drive(7'h00, 0, 1, 7'h0F, 0);
    expect_at(DIV * tgt + 1, 0, 8'h30, 0, 0, "R10 deferred post cancelled");
    idle_until(DIV * tgt + 2);
    expect_at(ecount + 1, 0, 8'h30, 0, 0, "R10 unmask does not repost");
    drive(7'h00, 0, 1, 7'h7F, 0);

    repeat (3) @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    #5;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule